// File: doc/BRIEF.md
# SPI NOR Flash Program Sequencer

This block carries a single-bit SPI NOR flash through a whole programming job with no processor in the loop. A host pulses `start` with a start address and a byte count. The sequencer then runs the job in this order:

1. It erases the sector that holds the start address.
2. It programs the bytes page by page. The bytes come from a local byte source through a valid/ready handshake.
3. After the erase and after each page, it polls the flash status until the flash is no longer busy.
4. It reads the whole range back and streams the bytes out on a read port.

Each erase and each page program is guarded by its own write-enable command. A page frame closes as soon as the running address crosses a 256-byte page boundary. The next page then gets a new write-enable, a new program header and a new busy poll.

The serial side works in clock mode 0. The bit rate is set by a parameterised divider, and chip select is held high for a minimum gap between commands.

Top module: `spi_flash_prog_seq`

## Requirements
- R1: After reset, and whenever no job is running, `spi_cs_n` is high, `spi_sck` is low, and `busy`, `done` and `wr_ready` are low.
- R2: Every erase frame and every page-program frame is preceded by its own 8-bit write-enable frame carrying byte 0x06. A later erase or program never reuses an earlier write-enable.
- R3: The first operation of a job is one sector erase. This is a 32-bit frame, MSB first, made of command byte 0x20 followed by the 24-bit start address. It comes before any program frame.
- R4: Data is written with program frames. Each frame is command byte 0x02, then the 24-bit address of its first byte, then data bytes MSB first in source order. A frame closes when the low 8 bits of the running address wrap to zero or when the byte count is used up. The first frame therefore carries min(count, 256 - start_addr[7:0]) bytes, and each later frame starts at the next page.
- R5: After each erase frame and each program frame, the block sends status-read frames (command 0x05). It keeps clocking in status bytes until bit 0 of a byte reads 0, and it issues no other command before that.
- R6: Once the last page is written and found idle, one read frame is sent: command 0x03 plus the start address. Then exactly `byte_count` bytes are clocked in MSB first, captured on the rising SCK edge. Each byte appears on `rd_data` with a one-cycle `rd_valid`, in address order.
- R7: SCK idles low and each bit is one high pulse. The high time is exactly CLK_DIV clock cycles and the low time is at least CLK_DIV cycles. SCK is low whenever chip select changes. Chip select stays high for at least 2*CLK_DIV cycles between frames.
- R8: `wr_ready` is high only while a program frame sits at a byte boundary after its 32-bit header, waiting for the next data byte. It is never high during a header, a write-enable or a status poll.
- R9: A `start` pulse while `busy` is high has no effect on the running job. A `start` with `byte_count` equal to 0 is ignored and the block stays idle.
- R10: `done` is high for exactly one cycle after the read frame closes. In that cycle `busy` is already low and all `byte_count` read bytes have been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle job request |
| start_addr | input | 24 | First flash byte address of the job |
| byte_count | input | CNT_W | Number of bytes to program and read back |
| busy | output | 1 | High while a job runs |
| done | output | 1 | One-cycle pulse at job end |
| wr_data | input | 8 | Byte from the source |
| wr_valid | input | 1 | Source byte available |
| wr_ready | output | 1 | Sequencer takes the byte this cycle |
| rd_data | output | 8 | Byte read back from flash |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A bit-level flash model decodes every frame, keeps a write-enable latch and reports busy for a random number of status bytes after each erase and program. This separates a missing or shared write-enable, and an early exit from polling, from correct behaviour.

The directed jobs cover three cases:
- A full 1 KB job that starts on a page boundary, covering four whole pages.
- A single byte at the last offset of a page, so the wrap and the end of the count coincide.
- A short range that straddles a page boundary, giving a partial first page.

Random jobs with a throttled byte source move the split points around and test the stall behaviour of `wr_ready`. A start pulse issued mid-job and a zero-count start confirm that such requests are ignored. The read-back data is compared against the source bytes.

// File: rtl/spi_flash_prog_seq.sv
module spi_flash_prog_seq #(
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      start_addr,
  input  logic [CNT_W-1:0] byte_count,
  output logic             busy,
  output logic             done,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  localparam int GAP = 2 * CLK_DIV;
  localparam int CW  = $clog2(GAP + 1);

  typedef enum logic [2:0] {F_IDLE, F_GAP, F_HDR, F_LOAD, F_BYTE, F_END} fsm_t;
  typedef enum logic [2:0] {OP_WREN, OP_ERASE, OP_POLL, OP_PROG, OP_READ} op_t;

  fsm_t             fsm;
  op_t              op;
  logic [31:0]      sh;
  logic [5:0]       bits;
  logic [CW-1:0]    cnt;
  logic             sck_q, erased, done_q, rdv_q;
  logic [7:0]       rx, rdd_q;
  logic [23:0]      addr, base;
  logic [CNT_W-1:0] remain, total;

  wire tick    = cnt == CW'(CLK_DIV - 1);
  wire gap_end = cnt == CW'(GAP - 1);

  assign busy     = fsm != F_IDLE;
  assign done     = done_q;
  assign wr_ready = fsm == F_LOAD;
  assign rd_data  = rdd_q;
  assign rd_valid = rdv_q;
  assign spi_cs_n = fsm == F_IDLE || fsm == F_GAP || fsm == F_END;
  assign spi_sck  = sck_q;
  assign spi_mosi = sh[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm <= F_IDLE; op <= OP_WREN; sh <= '0; bits <= '0; cnt <= '0;
      sck_q <= 1'b0; erased <= 1'b0; done_q <= 1'b0; rdv_q <= 1'b0;
      rx <= '0; rdd_q <= '0; addr <= '0; base <= '0; remain <= '0; total <= '0;
    end else begin
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      case (fsm)
        F_IDLE: if (start && byte_count != '0) begin
          op <= OP_WREN; erased <= 1'b0;
          addr <= start_addr; base <= start_addr;
          remain <= byte_count; total <= byte_count;
          cnt <= '0; fsm <= F_GAP;
        end
        F_GAP: if (gap_end) begin
          cnt <= '0;
          fsm <= F_HDR;
          case (op)
            OP_WREN:  begin sh <= {8'h06, 24'h0}; bits <= 6'd8;  end
            OP_ERASE: begin sh <= {8'h20, base};  bits <= 6'd32; end
            OP_POLL:  begin sh <= {8'h05, 24'h0}; bits <= 6'd8;  end
            OP_PROG:  begin sh <= {8'h02, addr};  bits <= 6'd32; end
            default:  begin sh <= {8'h03, base};  bits <= 6'd32; end
          endcase
        end else cnt <= cnt + 1'b1;
        F_HDR, F_BYTE: if (!tick) cnt <= cnt + 1'b1;
        else begin
          cnt <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx    <= {rx[6:0], spi_miso};
          end else begin
            sck_q <= 1'b0;
            sh    <= {sh[30:0], 1'b0};
            bits  <= bits - 1'b1;
            if (bits == 6'd1) begin
              if (fsm == F_HDR) begin
                case (op)
                  OP_WREN, OP_ERASE: fsm <= F_END;
                  OP_PROG:           fsm <= F_LOAD;
                  default: begin bits <= 6'd8; fsm <= F_BYTE; end
                endcase
              end else begin
                case (op)
                  OP_POLL: if (!rx[0]) fsm <= F_END; else bits <= 6'd8;
                  OP_PROG: begin
                    addr   <= addr + 1'b1;
                    remain <= remain - 1'b1;
                    if (remain == CNT_W'(1) || addr[7:0] == 8'hFF) fsm <= F_END;
                    else fsm <= F_LOAD;
                  end
                  default: begin
                    rdd_q  <= rx;
                    rdv_q  <= 1'b1;
                    remain <= remain - 1'b1;
                    if (remain == CNT_W'(1)) fsm <= F_END; else bits <= 6'd8;
                  end
                endcase
              end
            end
          end
        end
        F_LOAD: if (wr_valid) begin
          sh <= {wr_data, 24'h0}; bits <= 6'd8; cnt <= '0; fsm <= F_BYTE;
        end
        F_END: begin
          cnt <= '0;
          fsm <= F_GAP;
          case (op)
            OP_WREN:  op <= erased ? OP_PROG : OP_ERASE;
            OP_ERASE: begin op <= OP_POLL; erased <= 1'b1; end
            OP_PROG:  op <= OP_POLL;
            OP_POLL:  if (remain != '0) op <= OP_WREN;
                      else begin op <= OP_READ; addr <= base; remain <= total; end
            default:  begin fsm <= F_IDLE; done_q <= 1'b1; end
          endcase
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_cs_n && !spi_sck && !wr_ready));

  // R7
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> !spi_cs_n);

  // R7
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  // R8
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!spi_sck && !spi_cs_n));

  // R6
  rd_in_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/spi_flash_prog_seq_bench.sv
module spi_flash_prog_seq_bench;
  localparam int DIV   = 2;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] start_addr = '0;
  logic [CNT_W-1:0] byte_count = '0;
  logic busy, done, wr_ready, rd_valid, spi_cs_n, spi_sck, spi_mosi;
  logic [7:0] wr_data = '0, rd_data;
  logic wr_valid = 1'b0, spi_miso = 1'b0;

  always #4 clk = ~clk;

  spi_flash_prog_seq #(.CLK_DIV(DIV), .CNT_W(CNT_W)) u_spi_flash_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .busy(busy), .done(done), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int checks = 0, errors = 0;
  logic [7:0] mem [0:8191];
  logic [7:0] exp_data [0:1023];

  logic [23:0] j_start, exp_paddr, faddr;
  int j_count, exp_prem, rd_idx, feed_idx, done_seen;
  int n_wren, n_erase, n_prog, n_read;
  bit took, wel, finished;
  int fbits, hdr_len, busy_left, run_len;
  logic [7:0] fcmd, out_byte;
  logic [31:0] in_sh;
  logic prev_sck = 1'b0, prev_cs = 1'b1, prev_done = 1'b0;

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic int pages(logic [23:0] a, int n);
    return (int'(a[7:0]) + n + 255) / 256;
  endfunction

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic on_bit();
    int k;
    if (fbits == 8) begin
      fcmd = in_sh[7:0];
      hdr_len = (fcmd == 8'h05 || fcmd == 8'h06) ? 8 : 32;
      if (busy_left > 0 && fcmd != 8'h05) chk(0, "R5 command while busy", fcmd, 8'h05);
    end
    if (fbits == 32 && (fcmd == 8'h20 || fcmd == 8'h02 || fcmd == 8'h03)) begin
      faddr = in_sh[23:0];
      if (fcmd != 8'h03) begin
        chk(wel, "R2 write enable before erase/program", int'(wel), 1);
        wel = 0;
      end
    end
    if (fcmd == 8'h02 && fbits > 32 && (fbits - 32) % 8 == 0) begin
      k = (fbits - 32) / 8 - 1;
      mem[{faddr[12:8], 8'(faddr[7:0] + 8'(k))}] &= in_sh[7:0];
    end
    if (fcmd == 8'h05 && fbits > 8 && (fbits - 8) % 8 == 0 && busy_left > 0) busy_left--;
  endtask

  task automatic drive_out();
    int k;
    if (fbits >= 8 && fbits >= hdr_len && (fcmd == 8'h05 || fcmd == 8'h03)) begin
      if ((fbits - hdr_len) % 8 == 0) begin
        k = (fbits - hdr_len) / 8;
        if (fcmd == 8'h05) out_byte = (busy_left > 0) ? 8'h03 : 8'h00;
        else out_byte = mem[13'(faddr + 24'(k))];
      end
      spi_miso = out_byte[7 - ((fbits - hdr_len) % 8)];
    end
  endtask

  task automatic close_frame();
    int nb, en;
    nb = (fbits >= hdr_len && fbits >= 8) ? (fbits - hdr_len) / 8 : 0;
    case (fcmd)
      8'h06: begin chk(fbits == 8, "R2 write enable frame length", fbits, 8); wel = 1; n_wren++; end
      8'h20: begin
        n_erase++;
        chk(faddr == j_start, "R3 erase address", faddr, j_start);
        chk(n_prog == 0, "R3 erase before program", n_prog, 0);
        for (int i = 0; i < 4096; i++) mem[{faddr[12], 12'(i)}] = 8'hFF;
        busy_left = 1 + int'($urandom % 3);
      end
      8'h02: begin
        n_prog++;
        en = min2(exp_prem, 256 - int'(exp_paddr[7:0]));
        chk(faddr == exp_paddr, "R4 program address", faddr, exp_paddr);
        chk(nb == en, "R4 program frame bytes", nb, en);
        exp_paddr = exp_paddr + 24'(nb);
        exp_prem  = exp_prem - nb;
        busy_left = 1 + int'($urandom % 3);
      end
      8'h05: chk(busy_left == 0, "R5 poll ended while busy", busy_left, 0);
      8'h03: begin
        n_read++;
        chk(faddr == j_start, "R6 read address", faddr, j_start);
        chk(nb == j_count, "R6 read byte count", nb, j_count);
      end
      default: chk(0, "R2 unknown command", fcmd, 0);
    endcase
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_cs_n != prev_cs) chk(!spi_sck, "R7 sck low at cs edge", spi_sck, 0);
      if (!spi_cs_n && prev_cs) begin
        chk(run_len >= 2 * DIV, "R7 cs high gap", run_len, 2 * DIV);
        fbits = 0; fcmd = 8'h00; in_sh = '0; hdr_len = 8;
      end
      if (spi_cs_n && !prev_cs) close_frame();
      if (spi_sck && !prev_sck) begin
        chk(run_len >= DIV, "R7 sck low time", run_len, DIV);
        in_sh = {in_sh[30:0], spi_mosi};
        fbits++;
        on_bit();
      end
      if (!spi_sck && prev_sck) begin
        chk(run_len == DIV, "R7 sck high time", run_len, DIV);
        drive_out();
      end
      if (spi_sck != prev_sck || spi_cs_n != prev_cs) run_len = 1; else run_len++;
      if (wr_ready)
        chk(!spi_cs_n && fcmd == 8'h02 && fbits >= 32 && fbits % 8 == 0,
            "R8 ready outside data phase", fbits, 32);
      if (rd_valid) begin
        if (rd_idx < j_count) chk(rd_data == exp_data[rd_idx], "R6 read data", rd_data, exp_data[rd_idx]);
        else chk(0, "R6 extra read byte", rd_idx, j_count);
        rd_idx++;
      end
      if (done) begin
        done_seen++;
        chk(!busy, "R10 busy low with done", busy, 0);
        chk(rd_idx == j_count, "R10 all bytes before done", rd_idx, j_count);
      end
      if (done && prev_done) chk(0, "R10 done longer than one cycle", 2, 1);
    end
    prev_sck = spi_sck; prev_cs = spi_cs_n; prev_done = done;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (took) begin feed_idx++; wr_valid = 1'b0; end
      if (!wr_valid && feed_idx < j_count && ($urandom % 4 != 0)) begin
        wr_data = exp_data[feed_idx];
        wr_valid = 1'b1;
      end
      took = wr_valid && wr_ready;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  task automatic run_job(logic [23:0] a, int n, bit poke);
    int pg;
    @(negedge clk);
    j_start = a; j_count = n; exp_paddr = a; exp_prem = n;
    n_wren = 0; n_erase = 0; n_prog = 0; n_read = 0;
    rd_idx = 0; feed_idx = 0; took = 0; done_seen = 0;
    for (int i = 0; i < n; i++) exp_data[i] = 8'($urandom);
    start_addr = a; byte_count = CNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      start_addr = a ^ 24'h001000; byte_count = CNT_W'(7); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && !finished) @(negedge clk);
    repeat (4) @(negedge clk);
    pg = pages(a, n);
    chk(n_erase == 1, "R3 one erase per job", n_erase, 1);
    chk(n_prog == pg, "R4 page frame count", n_prog, pg);
    chk(n_wren == pg + 1, "R2 write enable count", n_wren, pg + 1);
    chk(exp_prem == 0, "R4 all bytes programmed", exp_prem, 0);
    chk(n_read == 1, "R6 one read frame", n_read, 1);
    chk(rd_idx == n, "R6 bytes returned", rd_idx, n);
    chk(done_seen == 1, "R10 single done", done_seen, 1);
    chk(!busy && spi_cs_n && !spi_sck, "R9 no new job after ignored start", busy, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R10: actual timeout expected done");
    summary();
    $finish;
  end

  initial begin
    int n;
    logic [23:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    j_count = 0; feed_idx = 0; busy_left = 0; run_len = 100;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n, "R1 cs idle high", spi_cs_n, 1);
    chk(!spi_sck, "R1 sck idle low", spi_sck, 0);
    chk(!busy, "R1 busy low", busy, 0);
    chk(!wr_ready, "R1 ready low", wr_ready, 0);
    chk(!done, "R1 done low", done, 0);

    run_job(24'h000000, 1024, 1'b1);
    run_job(24'h3A10FF, 1, 1'b0);
    run_job(24'h0011F0, 40, 1'b0);

    @(negedge clk);
    start_addr = 24'h000100; byte_count = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(!busy, "R9 zero count ignored", busy, 0);
    chk(spi_cs_n, "R9 zero count leaves cs high", spi_cs_n, 1);

    for (int r = 0; r < 2; r++) begin
      n = 1 + int'($urandom % 200);
      a = {11'($urandom), 1'($urandom), 12'($urandom % (4096 - n))};
      run_job(a, n, 1'b0);
    end

    summary();
    $finish;
  end
endmodule